// File: doc/BRIEF.md
# Strap-Configured Expansion ROM Controller

This block lets a host adapter find and read an external boot ROM with no firmware setup. Pull-down resistors sit on a shared multiplexed address/data bus. On the first clock after reset the block samples that bus. The pattern of low pins gives the ROM size, and one pin selects a slow-access mode. Each pin found pulled low then has its internal pull-up switched off, which saves current.

The decoded size is presented through an expansion ROM base address register. Software learns the size the usual way: it writes all ones and reads back a mask. Once the enable bit is set and a base is programmed, byte reads that fall inside the window are sequenced to the ROM. A fast read takes three clocks and a slow read takes five. A separate control bit drives the programming-voltage enable for a flash device.

Top module: `xrom_strap_ctrl`

## Requirements
- R1: The bus value `madIn` is captured on the first rising clock edge after `rstN` goes high. It is held until the next reset, whatever the bus does afterwards. `pullUpEn` is all ones until that capture. After the capture, `pullUpEn[i]` equals the captured value of pin i, so it is 0 for every pin that was pulled low.
- R2: The size code is {~pin3, ~pin2, ~pin1}. The codes map to window sizes as follows: 001 gives 16 KB, 010 gives 64 KB, 011 gives 128 KB, 100 gives 256 KB, 101 gives 512 KB, 110 gives 32 KB and 111 gives 1 MB.
- R3: When pins 3..1 are all captured high (code 000), there is no ROM. The BAR reads 0, BAR writes are ignored and read requests are never accepted.
- R4: After all ones is written to the BAR (`cfgSel`=0), it reads back ones from bit 31 down to bit log2(size). Bits log2(size)-1 down to 1 read back zero. Bit 0 is the enable bit and is writable.
- R5: A captured 0 on pin 0 selects slow mode. A captured 1 selects fast mode.
- R6: An accepted fast read raises `done` for one cycle, three rising edges after the accepting edge. `rdData` then holds the bus value that was present before the last of those edges.
- R7: An accepted slow read raises `done` five rising edges after the accepting edge, which is exactly two more than a fast read.
- R8: A request is ignored in any of these cases: BAR bit 0 is clear, the address bits from 31 down to log2(size) differ from the BAR, or the block is busy. An ignored request produces no `done`.
- R9: Writing with `cfgSel`=1 loads bit 0 of `cfgWdata` into `vppEn`. `vppEn` resets to 0, and BAR writes leave it unchanged.
- R10: During an access, `romAddr` equals the request address masked to the low log2(size) bits. `romCeN` is low from the cycle after acceptance until `done`, and `busy` is high over the same span.
- R11: A request that arrives on the same edge as a BAR write is decoded against the BAR contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| madIn | input | 8 | Shared bus: straps after reset, ROM data during reads |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the BAR, 1 selects the control register |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration read data for the selected register |
| reqValid | input | 1 | ROM byte read request |
| reqAddr | input | 32 | Request address |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle pulse marking a valid `rdData` |
| rdData | output | 8 | Byte returned from the ROM |
| romAddr | output | 20 | ROM byte offset |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| pullUpEn | output | 8 | Per-pin internal pull-up enable |
| vppEn | output | 1 | Flash programming-voltage enable |

## Verification
Two functions can fall on the same edge: a configuration write that clears the BAR enable bit, and a read request aimed inside the current window. The bench drives both on one cycle. It then judges the result by whether `done` appears at the fast latency: the request must be accepted, because it is decoded against the old enable. A second request issued afterwards must be ignored, which confirms that the write did take effect. A request issued while a read is in flight is also checked: it must not cause a second `done` or disturb `romAddr`.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

  typedef struct packed {
    logic capStrap;
    logic loadReq;
    logic latchData;
  } ctlStrobe_t;

  typedef enum logic [2:0] {
    ST_CAP  = 3'd0,
    ST_IDLE = 3'd1,
    ST_ADDR = 3'd2,
    ST_ACC  = 3'd3,
    ST_WAIT = 3'd4,
    ST_DATA = 3'd5
  } romState_t;

  // size code {~p3,~p2,~p1} -> log2 of window bytes (0 = no ROM)
  function automatic logic [4:0] sizeLog2(input logic [2:0] code);
    logic [4:0] r;
    case (code)
      3'b001:  r = 5'd14;
      3'b010:  r = 5'd16;
      3'b011:  r = 5'd17;
      3'b100:  r = 5'd18;
      3'b101:  r = 5'd19;
      3'b110:  r = 5'd15;
      3'b111:  r = 5'd20;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/xrom_control.sv
module xrom_control
  import xrom_pkg::*;
#(
  parameter int SLOW_EXTRA = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqHit,
  input  logic       slowMode,
  output ctlStrobe_t stb,
  output logic       busy,
  output logic       romCeN,
  output logic       romOeN
);

  localparam int CNT_W = (SLOW_EXTRA > 1) ? $clog2(SLOW_EXTRA) : 1;

  romState_t state, nxtState;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    nxtState = state;
    stb      = '0;
    case (state)
      ST_CAP: begin
        stb.capStrap = 1'b1;
        nxtState     = ST_IDLE;
      end
      ST_IDLE: begin
        if (reqValid && reqHit) begin
          stb.loadReq = 1'b1;
          nxtState    = ST_ADDR;
        end
      end
      ST_ADDR: nxtState = ST_ACC;
      ST_ACC:  nxtState = (slowMode && (SLOW_EXTRA > 0)) ? ST_WAIT : ST_DATA;
      ST_WAIT: if (waitCnt == '0) nxtState = ST_DATA;
      ST_DATA: begin
        stb.latchData = 1'b1;
        nxtState      = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_CAP;
    else       state <= nxtState;
  end

  generate
    if (SLOW_EXTRA > 0) begin : g_waitCnt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                               waitCnt <= '0;
        else if (state == ST_ACC)                waitCnt <= CNT_W'(SLOW_EXTRA - 1);
        else if (state == ST_WAIT && waitCnt != '0) waitCnt <= waitCnt - 1'b1;
      end
    end else begin : g_noWait
      assign waitCnt = '0;
    end
  endgenerate

  assign busy   = (state != ST_IDLE) && (state != ST_CAP);
  assign romCeN = !busy;
  assign romOeN = !((state == ST_ACC) || (state == ST_WAIT) || (state == ST_DATA));

  // checker: cycles since acceptance
  logic [3:0] cycCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cycCnt <= '0;
    else if (stb.loadReq) cycCnt <= '0;
    else if (busy)        cycCnt <= cycCnt + 1'b1;
  end

  // R6 fast length, R7 slow length
  a_r6_access_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA) |-> (cycCnt == (slowMode ? 4'(2 + SLOW_EXTRA) : 4'd2)));

  a_r8_miss_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqValid && !reqHit) |=> (state == ST_IDLE));

  a_r10_oe_within_ce: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN);

endmodule

// File: rtl/xrom_datapath.sv
module xrom_datapath
  import xrom_pkg::*;
#(
  parameter int STRAP_W    = 8,
  parameter int BAR_W      = 32,
  parameter int ROM_ADDR_W = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            stb,
  input  logic [STRAP_W-1:0]    madIn,
  input  logic                  cfgWe,
  input  logic                  cfgSel,
  input  logic [BAR_W-1:0]      cfgWdata,
  output logic [BAR_W-1:0]      cfgRdata,
  input  logic [BAR_W-1:0]      reqAddr,
  output logic                  reqHit,
  output logic                  slowMode,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic [STRAP_W-1:0]    rdData,
  output logic                  done,
  output logic [STRAP_W-1:0]    pullUpEn,
  output logic                  vppEn
);

  logic [STRAP_W-1:0] strapReg;
  logic               capDone;
  logic [2:0]         sizeCode;
  logic [4:0]         winLog2;
  logic               romPresent;
  logic [BAR_W-1:0]   sizeMask;
  logic [BAR_W-1:0]   writable;
  logic [BAR_W-1:0]   barReg;
  logic               vppReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapReg <= '1;
      capDone  <= 1'b0;
    end else if (stb.capStrap) begin
      strapReg <= madIn;
      capDone  <= 1'b1;
    end
  end

  assign sizeCode   = ~strapReg[3:1];
  assign winLog2    = sizeLog2(sizeCode);
  assign romPresent = capDone && (sizeCode != 3'b000);
  assign sizeMask   = romPresent ? ({BAR_W{1'b1}} << winLog2) : '0;
  assign writable   = romPresent ? (sizeMask | BAR_W'(1)) : '0;
  assign slowMode   = capDone && !strapReg[0];
  assign pullUpEn   = capDone ? strapReg : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barReg <= '0;
      vppReg <= 1'b0;
    end else if (cfgWe) begin
      if (cfgSel) vppReg <= cfgWdata[0];
      else        barReg <= cfgWdata & writable;
    end
  end

  assign cfgRdata = cfgSel ? BAR_W'(vppReg) : barReg;
  assign vppEn    = vppReg;
  assign reqHit   = romPresent && barReg[0] && (((reqAddr ^ barReg) & sizeMask) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romAddr <= '0;
      rdData  <= '0;
      done    <= 1'b0;
    end else begin
      done <= stb.latchData;
      if (stb.loadReq)   romAddr <= reqAddr[ROM_ADDR_W-1:0] & ~sizeMask[ROM_ADDR_W-1:0];
      if (stb.latchData) rdData  <= madIn;
    end
  end

  a_r1_straps_held: assert property (@(posedge clk) disable iff (!rstN)
    capDone |=> $stable(pullUpEn));

  a_r3_no_rom_bar: assert property (@(posedge clk) disable iff (!rstN)
    (capDone && !romPresent) |-> (barReg == '0));

  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    capDone |-> ((barReg & ~writable) == '0));

  a_r9_vpp_load: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel) |=> (vppEn == $past(cfgWdata[0])));

endmodule

// File: rtl/xrom_strap_ctrl.sv
module xrom_strap_ctrl
  import xrom_pkg::*;
#(
  parameter int STRAP_W    = 8,
  parameter int BAR_W      = 32,
  parameter int ROM_ADDR_W = 20,
  parameter int SLOW_EXTRA = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STRAP_W-1:0]    madIn,
  input  logic                  cfgWe,
  input  logic                  cfgSel,
  input  logic [BAR_W-1:0]      cfgWdata,
  output logic [BAR_W-1:0]      cfgRdata,
  input  logic                  reqValid,
  input  logic [BAR_W-1:0]      reqAddr,
  output logic                  busy,
  output logic                  done,
  output logic [STRAP_W-1:0]    rdData,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  romCeN,
  output logic                  romOeN,
  output logic [STRAP_W-1:0]    pullUpEn,
  output logic                  vppEn
);

  ctlStrobe_t stb;
  logic       reqHit;
  logic       slowMode;

  xrom_control #(.SLOW_EXTRA(SLOW_EXTRA)) uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHit(reqHit),
    .slowMode(slowMode), .stb(stb), .busy(busy),
    .romCeN(romCeN), .romOeN(romOeN)
  );

  xrom_datapath #(.STRAP_W(STRAP_W), .BAR_W(BAR_W), .ROM_ADDR_W(ROM_ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .madIn(madIn),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqAddr(reqAddr), .reqHit(reqHit), .slowMode(slowMode),
    .romAddr(romAddr), .rdData(rdData), .done(done),
    .pullUpEn(pullUpEn), .vppEn(vppEn)
  );

endmodule

// File: tb/sim_xrom_strap_ctrl.sv
module sim_xrom_strap_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  madIn = 8'hFF;
  logic        cfgWe = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        busy, done, romCeN, romOeN, vppEn;
  logic [7:0]  rdData, pullUpEn;
  logic [19:0] romAddr;

  int nChk = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  xrom_strap_ctrl u0 (
    .clk(clk), .rstN(rstN), .madIn(madIn), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy), .done(done), .rdData(rdData), .romAddr(romAddr),
    .romCeN(romCeN), .romOeN(romOeN), .pullUpEn(pullUpEn), .vppEn(vppEn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // size table from R2: returns log2 of window, 0 when no ROM
  function automatic int expLog2(input logic [7:0] s);
    case ({~s[3], ~s[2], ~s[1]})
      3'b001: return 14;
      3'b010: return 16;
      3'b011: return 17;
      3'b100: return 18;
      3'b101: return 19;
      3'b110: return 15;
      3'b111: return 20;
      default: return 0;
    endcase
  endfunction

  task automatic rstWith(input logic [7:0] strap);
    @(negedge clk);
    rstN = 1'b0; madIn = strap; reqValid = 1'b0; cfgWe = 1'b0;
    repeat (2) @(negedge clk);
    chk(pullUpEn == 8'hFF, "R1 pullups before capture", 32'(pullUpEn), 32'hFF);
    chk(vppEn == 1'b0, "R9 vpp reset", 32'(vppEn), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pullUpEn == strap, "R1 pullups after capture", 32'(pullUpEn), 32'(strap));
    madIn = 8'h00;
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] d);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic barSize(input logic [7:0] strap, input string tag);
    int l;
    logic [31:0] exp;
    rstWith(strap);
    l = expLog2(strap);
    exp = (l == 0) ? 32'h0 : ((32'hFFFF_FFFF << l) | 32'h1);
    cfgWrite(1'b0, 32'hFFFF_FFFF);
    cfgSel = 1'b0;
    #1;
    chk(cfgRdata == exp, tag, cfgRdata, exp);
  endtask

  // issues a request, returns edges until done (99 = none)
  task automatic romRead(input logic [31:0] addr, input logic [7:0] data,
                         output int lat, output logic [7:0] got, output logic [19:0] ra,
                         output logic ceLow);
    reqValid = 1'b1; reqAddr = addr; madIn = data;
    @(negedge clk);
    reqValid = 1'b0;
    ra = romAddr; ceLow = !romCeN && busy;
    lat = 99; got = 8'h00;
    for (int n = 0; n < 10; n++) begin
      if (done && lat == 99) begin lat = n; got = rdData; end
      @(negedge clk);
    end
  endtask

  task automatic t_fastRead;
    int lat; logic [7:0] got; logic [19:0] ra; logic ce;
    rstWith(8'hF3);
    chk(pullUpEn == 8'hF3, "R1 low pins lose pullup", 32'(pullUpEn), 32'hF3);
    cfgWrite(1'b0, 32'h000C_0000);
    romRead(32'h000C_5ABC, 8'hA5, lat, got, ra, ce);
    chk(lat == 99, "R8 enable clear ignored", lat, 99);
    cfgWrite(1'b0, 32'h000C_0001);
    romRead(32'h000C_5ABC, 8'hA5, lat, got, ra, ce);
    chk(lat == 3, "R6 fast latency", lat, 3);
    chk(got == 8'hA5, "R6 read data", 32'(got), 32'hA5);
    chk(ra == 20'h05ABC, "R10 rom address", 32'(ra), 32'h5ABC);
    chk(ce, "R10 chip enable while busy", 32'(ce), 1);
    romRead(32'h000D_0010, 8'h3C, lat, got, ra, ce);
    chk(lat == 99, "R8 outside window ignored", lat, 99);
  endtask

  task automatic t_busyIgnore;
    int seen = 0;
    rstWith(8'hF3);
    cfgWrite(1'b0, 32'h0000_8001);
    reqValid = 1'b1; reqAddr = 32'h0000_8111; madIn = 8'h5A;
    @(negedge clk);
    reqAddr = 32'h0000_8222;
    @(negedge clk);
    reqValid = 1'b0;
    for (int n = 0; n < 10; n++) begin
      if (done) seen++;
      @(negedge clk);
    end
    chk(seen == 1, "R8 busy request ignored", seen, 1);
    chk(romAddr == 20'h00111, "R8 address unchanged", 32'(romAddr), 32'h111);
  endtask

  task automatic t_slowRead;
    int lat; logic [7:0] got; logic [19:0] ra; logic ce;
    rstWith(8'hF2);
    cfgWrite(1'b0, 32'h0001_0001);
    romRead(32'h0001_0042, 8'h77, lat, got, ra, ce);
    chk(lat == 5, "R5 R7 slow latency", lat, 5);
    chk(got == 8'h77, "R7 slow read data", 32'(got), 32'h77);
  endtask

  task automatic t_noRom;
    int lat; logic [7:0] got; logic [19:0] ra; logic ce;
    barSize(8'hFF, "R3 no rom bar reads zero");
    romRead(32'h0000_0000, 8'h11, lat, got, ra, ce);
    chk(lat == 99, "R3 no rom request ignored", lat, 99);
  endtask

  task automatic t_vpp;
    rstWith(8'hF3);
    cfgWrite(1'b1, 32'h0000_0001);
    chk(vppEn == 1'b1, "R9 vpp set", 32'(vppEn), 1);
    cfgWrite(1'b0, 32'hFFFF_FFFE);
    chk(vppEn == 1'b1, "R9 vpp kept on bar write", 32'(vppEn), 1);
    cfgSel = 1'b1; #1;
    chk(cfgRdata == 32'h1, "R9 vpp readback", cfgRdata, 1);
    cfgWrite(1'b1, 32'h0000_0000);
    chk(vppEn == 1'b0, "R9 vpp clear", 32'(vppEn), 0);
  endtask

  task automatic t_collide;
    int lat; logic [7:0] got; logic [19:0] ra; logic ce;
    rstWith(8'hF3);
    cfgWrite(1'b0, 32'h0000_8001);
    cfgWe = 1'b1; cfgSel = 1'b0; cfgWdata = 32'h0000_8000;
    reqValid = 1'b1; reqAddr = 32'h0000_8003; madIn = 8'hC3;
    @(negedge clk);
    cfgWe = 1'b0; reqValid = 1'b0;
    lat = 99;
    for (int n = 0; n < 8; n++) begin
      if (done && lat == 99) lat = n;
      @(negedge clk);
    end
    chk(lat == 3, "R11 same-edge request uses old BAR", lat, 3);
    romRead(32'h0000_8003, 8'hC3, lat, got, ra, ce);
    chk(lat == 99, "R11 write took effect", lat, 99);
  endtask

  task automatic t_strapHeld;
    rstWith(8'hF1);
    repeat (3) @(negedge clk);
    chk(pullUpEn == 8'hF1, "R1 straps held after bus changes", 32'(pullUpEn), 32'hF1);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    t_fastRead();
    t_busyIgnore();
    t_slowRead();
    t_noRom();
    barSize(8'hF3, "R2 R4 32KB mask");
    barSize(8'hF1, "R2 R4 1MB mask");
    barSize(8'hFD, "R2 R4 16KB mask");
    barSize(8'hF7, "R2 R4 256KB mask");
    t_vpp();
    t_collide();
    t_strapHeld();
    finishRun();
  end

endmodule